// File: doc/BRIEF.md
# Shared Free-Running Counter with Run/Stop Control

This block keeps one free-running counter that every processor-local compare unit in an interrupt controller watches. The counter advances by one on every clock while running. A global configuration register holds a run/stop bit. The same register also reports the size of the controller: how many interrupt sources it has and how many processors it serves. The count is driven continuously on a dedicated output so that the compare units can use it.

Software reaches the block through a plain register interface. A write is a single-cycle strobe with a write flag, an address and data. Read data is a combinational function of the address and the current state. The count can be read at a privileged address and at a read-only alias for user code. Each has a high word that is always zero. The count can be overwritten only while it is halted. This lets software set a known start value without racing the clock.

Top module: `gcnt_shared_timer`

## Requirements
- R1: After reset the count is 0, the stop bit is 0, and counting starts on the first clock edge after reset is released.
- R2: While running, the count rises by exactly one per clock and wraps from 0xFFFFFFFF to 0.
- R3: Writing 1 to configuration bit 28 halts the count (the edge that takes the write still counts once). Writing 0 resumes counting (the edge that takes the write does not count). While halted the count holds its value.
- R4: A write to the low count word (offset 0x010) while halted loads the written value. It is visible one clock later.
- R5: A write to the low count word while running is ignored, and counting carries on unchanged.
- R6: The configuration word (offset 0x000) reads with the stop bit at bit 28, (sources/8)-1 at bits 23:16, and the processor count at bits 5:0. All other bits read 0, including the counter-width field.
- R7: The privileged high count word (0x014) and the user high count word (0x804) always read 0.
- R8: The user low count word (0x800) reads the same value as the privileged low word and the count output.
- R9: Writes to 0x800 or 0x804 are ignored even while halted. A configuration write changes nothing but the stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cnt_o | output | CNT_W | Current count for the compare units |

## Verification
The bench builds the block with 64 sources and 6 processors. With these values the topology fields read 7 and 6. This separates them from the defaults, so a field placed at the wrong bit offset, or a wrong source encoding, changes the configuration word visibly. Because the counter can be loaded while halted, the bench can place the count at 0xFFFFFFFE and reach the wrap in a few cycles without running through 2^32 clocks.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_CFG  = 12'h000;
    localparam logic [REG_AW-1:0] OFS_LO   = 12'h010;
    localparam logic [REG_AW-1:0] OFS_HI   = 12'h014;
    localparam logic [REG_AW-1:0] OFS_ULO  = 12'h800;
    localparam logic [REG_AW-1:0] OFS_UHI  = 12'h804;

    localparam int STOP_BIT   = 28;
    localparam int SRC_LSB    = 16;
    localparam int SRC_W      = 8;
    localparam int PROC_LSB   = 0;
    localparam int PROC_W     = 6;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_LO,
        SEL_HI,
        SEL_ULO,
        SEL_UHI
    } reg_sel_e;

endpackage

// File: rtl/gcnt_addr_dec.sv
module gcnt_addr_dec
    import gcnt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFS_CFG)) sel = SEL_CFG;
        if (addr == ADDR_W'(OFS_LO))  sel = SEL_LO;
        if (addr == ADDR_W'(OFS_HI))  sel = SEL_HI;
        if (addr == ADDR_W'(OFS_ULO)) sel = SEL_ULO;
        if (addr == ADDR_W'(OFS_UHI)) sel = SEL_UHI;
    end
endmodule

// File: rtl/gcnt_core.sv
module gcnt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             stop_wval,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic             stop_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic             stop;
        logic [CNT_W-1:0] count;
    } core_st_t;

    localparam core_st_t RST_ST = '{stop: 1'b0, count: '0};

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // count follows the stop state held before this edge
        if (!st_q.stop) begin
            st_d.count = st_q.count + CNT_W'(1);
        end else if (load_wr) begin
            st_d.count = load_val;
        end
        if (cfg_wr && (stop_wval != st_q.stop)) begin
            st_d.stop = stop_wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign stop_o  = st_q.stop;
    assign count_o = st_q.count;
endmodule

// File: rtl/gcnt_rdmux.sv
module gcnt_rdmux
    import gcnt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_SRC  = 256,
    parameter int NUM_PROC = 4
) (
    input  reg_sel_e         sel,
    input  logic             stop,
    input  logic [CNT_W-1:0] count,
    output logic [31:0]      rdata
);
    localparam logic [SRC_W-1:0]  SRC_CODE  = SRC_W'(NUM_SRC / 8 - 1);
    localparam logic [PROC_W-1:0] PROC_CODE = PROC_W'(NUM_PROC);

    logic [31:0] cfg_word;

    always_comb begin
        cfg_word = '0;
        cfg_word[STOP_BIT]                 = stop;
        cfg_word[SRC_LSB +: SRC_W]         = SRC_CODE;
        cfg_word[PROC_LSB +: PROC_W]       = PROC_CODE;
    end

    always_comb begin
        unique case (sel)
            SEL_CFG:         rdata = cfg_word;
            SEL_LO, SEL_ULO: rdata = 32'(count);
            default:         rdata = '0;
        endcase
    end
endmodule

// File: rtl/gcnt_shared_timer.sv
module gcnt_shared_timer
    import gcnt_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 32,
    parameter int NUM_SRC  = 256,
    parameter int NUM_PROC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [CNT_W-1:0]  cnt_o
);
    reg_sel_e   acc_sel;
    logic       run_stop;
    logic       cfg_wr;
    logic       lo_wr;

    gcnt_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (acc_sel)
    );

    assign cfg_wr = bus_wr && (acc_sel == SEL_CFG);
    assign lo_wr  = bus_wr && (acc_sel == SEL_LO);

    gcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .stop_wval (bus_wdata[STOP_BIT]),
        .load_wr   (lo_wr),
        .load_val  (CNT_W'(bus_wdata)),
        .stop_o    (run_stop),
        .count_o   (cnt_o)
    );

    gcnt_rdmux #(
        .CNT_W    (CNT_W),
        .NUM_SRC  (NUM_SRC),
        .NUM_PROC (NUM_PROC)
    ) u_rd (
        .sel   (acc_sel),
        .stop  (run_stop),
        .count (cnt_o),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/gcnt_shared_timer_chk.sv
module gcnt_shared_timer_chk
    import gcnt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              run_stop
);
    logic lo_hit;
    logic hi_hit;
    logic ulo_hit;
    assign lo_hit  = (bus_addr == ADDR_W'(OFS_LO));
    assign ulo_hit = (bus_addr == ADDR_W'(OFS_ULO));
    assign hi_hit  = (bus_addr == ADDR_W'(OFS_HI)) || (bus_addr == ADDR_W'(OFS_UHI));

    // R2: running count steps by one, wrapping
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        !run_stop |=> (cnt_o - $past(cnt_o)) == CNT_W'(1));

    // R3: halted count holds unless loaded
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_stop && !(bus_wr && lo_hit)) |=> $stable(cnt_o));

    // R4: load while halted
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (run_stop && bus_wr && lo_hit) |=> cnt_o == $past(CNT_W'(bus_wdata)));

    // R6: stop bit read back matches halt state
    a_r6_stopbit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CFG)) |-> bus_rdata[STOP_BIT] == run_stop);

    // R7: high words read zero
    a_r7_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hi_hit |-> bus_rdata == 32'd0);

    // R8: both low words show the count
    a_r8_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_hit || ulo_hit) |-> bus_rdata == 32'(cnt_o));
endmodule

bind gcnt_shared_timer gcnt_shared_timer_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_o     (cnt_o),
    .run_stop  (run_stop)
);

// File: tb/test_gcnt_shared_timer.sv
`timescale 1ns/1ps
module test_gcnt_shared_timer;
    localparam int AW = 12;
    localparam int CW = 32;
    localparam logic [11:0] A_CFG = 12'h000;
    localparam logic [11:0] A_LO  = 12'h010;
    localparam logic [11:0] A_HI  = 12'h014;
    localparam logic [11:0] A_ULO = 12'h800;
    localparam logic [11:0] A_UHI = 12'h804;
    localparam logic [31:0] TOPO  = 32'h0007_0006;
    localparam logic [31:0] STOPW = 32'h1000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [CW-1:0] cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gcnt_shared_timer #(
        .ADDR_W(AW), .CNT_W(CW), .NUM_SRC(64), .NUM_PROC(6)
    ) i_gcnt_shared_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_o(cnt_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // drive at a negedge; the write lands at the next posedge; returns at next negedge
    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_CFG;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CFG, v);
        chk("R1 cfg after reset", v, TOPO);
        chk("R1 count after reset", cnt_o, 32'd0);
    endtask

    task automatic t_run;
        logic [31:0] v0;
        rd(A_LO, v0);
        repeat (5) @(negedge clk);
        chk("R2 five clocks", cnt_o, v0 + 32'd5);
    endtask

    task automatic t_stop_hold;
        logic [31:0] v0;
        logic [31:0] v1;
        v0 = cnt_o;
        wr(A_CFG, STOPW | 32'h00AB_00FF);
        chk("R3 stop edge counts once", cnt_o, v0 + 32'd1);
        v1 = cnt_o;
        repeat (4) @(negedge clk);
        chk("R3 held while halted", cnt_o, v1);
        rd(A_CFG, v0);
        chk("R6 cfg halted", v0, TOPO | STOPW);
        wr(A_CFG, STOPW);
        chk("R3 same stop value no change", cnt_o, v1);
    endtask

    task automatic t_load_wrap;
        logic [31:0] v;
        wr(A_LO, 32'hFFFF_FFFE);
        chk("R4 load while halted", cnt_o, 32'hFFFF_FFFE);
        wr(A_ULO, 32'h0000_1234);
        chk("R9 user lo write ignored", cnt_o, 32'hFFFF_FFFE);
        wr(A_UHI, 32'h0000_5678);
        rd(A_HI, v);
        chk("R7 hi after user hi write", v, 32'd0);
        chk("R9 user hi write ignored", cnt_o, 32'hFFFF_FFFE);
        wr(A_CFG, 32'h0000_0000);
        chk("R3 resume edge holds", cnt_o, 32'hFFFF_FFFE);
        @(negedge clk);
        chk("R2 reaches max", cnt_o, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R2 wraps to zero", cnt_o, 32'd0);
        rd(A_CFG, v);
        chk("R6 cfg running", v, TOPO);
    endtask

    task automatic t_load_running;
        logic [31:0] v0;
        v0 = cnt_o;
        wr(A_LO, 32'h0BAD_0000);
        chk("R5 load ignored while running", cnt_o, v0 + 32'd1);
        @(negedge clk);
        chk("R5 counting unchanged", cnt_o, v0 + 32'd2);
    endtask

    task automatic t_reads;
        logic [31:0] v;
        rd(A_HI, v);
        chk("R7 priv hi zero", v, 32'd0);
        rd(A_UHI, v);
        chk("R7 user hi zero", v, 32'd0);
        rd(A_ULO, v);
        chk("R8 user lo equals count", v, cnt_o);
        rd(A_LO, v);
        chk("R8 priv lo equals count", v, cnt_o);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_run();
        t_stop_hold();
        t_load_wrap();
        t_load_running();
        t_reads();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule